// File: doc/BRIEF.md
# Serial Memory Write-Cycle and Protect Controller

This block sits beside the serial front end of a nonvolatile memory slave and decides when an internal programming cycle begins and ends. It watches the active-low select pin, the active-low write-protect pin and the protect-enable bit of the status register. It also watches two flags from the command decoder: one marks a complete, valid write sequence, and the other marks that sequence as a status-register write. The pins and the decoder flags come from outside the system clock domain. Each passes through a two-flop synchronizer before any decision is made.

A cycle is launched only when select rises at the end of a valid sequence. Once launched, the cycle cannot be stopped. The busy flag stays high for a fixed number of system clocks, and select activity during that time changes nothing. A status-register write is refused when protection is enabled and the protect pin is low. A refused write produces no cycle at all. The protect pin is looked at only at the launching edge.

The controller is a five-state machine:
- `ST_WAIT_SEL`: power-up, nothing accepted yet.
- `ST_IDLE`: deselected standby.
- `ST_SELECTED`: select low.
- `ST_LAUNCH`: the first busy cycle, during which the start strobe is high.
- `ST_PROG`: the rest of the programming time.

Its transitions are:
- WAIT_SEL→SELECTED and IDLE→SELECTED when synchronized select is low.
- SELECTED→LAUNCH on a select rise with an accepted sequence.
- SELECTED→IDLE on any other select rise.
- LAUNCH→PROG always.
- PROG→SELECTED or PROG→IDLE when the timer expires, chosen by the select level at that moment.

Top module: `wcyc_ctrl`

## Requirements
- R1: After reset, busy, cyc_start and stat_wr_en are 0 and standby is 1.
- R2: standby is 1 exactly when no cycle is running and the synchronized select is high. It falls on the third clock edge after sel_n is driven low.
- R3: A select rise launches a cycle when wr_seq_ok is 1 at that rise. At launch, cyc_start is high for one cycle, starting on the third clock edge after sel_n rises.
- R4: busy is high for exactly PROG_CYCLES consecutive clocks (minimum 2), starting in the cyc_start cycle.
- R5: While busy is high, select toggling does not shorten the cycle and launches no new cycle.
- R6: If select is low when the cycle ends, standby stays 0. It rises only after select is later seen high.
- R7: A status write (wr_seq_stat=1) with prot_en=1 and wprot_n=0 at the select rise produces no cyc_start, no busy and no stat_wr_en.
- R8: With prot_en=0, a status write launches whatever wprot_n is. stat_wr_en pulses in the same cycle as cyc_start.
- R9: A change of wprot_n after launch alters neither busy length nor stat_wr_en.
- R10: Before select is first seen low after reset, wr_seq_ok has no effect and no cycle launches.
- R11: A non-status write (wr_seq_stat=0) launches regardless of wprot_n and prot_en, with stat_wr_en held 0.
- R12: A select rise with wr_seq_ok=0 launches nothing and returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select pin (asynchronous) |
| wprot_n | input | 1 | Active-low write-protect pin (asynchronous) |
| prot_en | input | 1 | Protect-enable status bit (system domain) |
| wr_seq_ok | input | 1 | Decoder flag: valid write sequence received (serial-clock domain) |
| wr_seq_stat | input | 1 | Decoder flag: the sequence targets the status register (serial-clock domain) |
| busy | output | 1 | Programming cycle in progress |
| standby | output | 1 | Deselected and idle |
| stat_wr_en | output | 1 | Status-register commit strobe, coincident with cyc_start |
| cyc_start | output | 1 | One-cycle internal cycle-start pulse |

## Verification
A pin or flag change driven between edges reaches the state register on the third rising edge. It passes the two synchronizer stages first, and the state register then acts on it. standby, cyc_start and stat_wr_en therefore move after that third edge. busy follows for PROG_CYCLES edges after that. The bench keeps a behavioural model that delays each input by two edges in a queue and applies the rules at the next edge. The model is compared with the outputs 5 ns after every rising edge. Scenario checks also compare per-scenario counts of start pulses, status strobes and busy cycles, so the exact cycle length and the lack of any launch are checked directly.

// File: rtl/wcyc_pkg.sv
package wcyc_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_SEL,
        ST_IDLE,
        ST_SELECTED,
        ST_LAUNCH,
        ST_PROG
    } wc_state_e;

    // synchronizer lane assignment
    localparam int SYNC_W  = 4;
    localparam int IDX_SEL = 0;
    localparam int IDX_WP  = 1;
    localparam int IDX_OK  = 2;
    localparam int IDX_ST  = 3;

    // select and protect pins reset to their inactive (high) level
    localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0011;

endpackage

// File: rtl/wcyc_sync.sv
module wcyc_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic s1, s2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[i];
                    s2 <= RST_VAL[i];
                end else begin
                    s1 <= d[i];
                    s2 <= s1;
                end
            end
            assign q[i] = s2;
        end
    endgenerate
endmodule

// File: rtl/wcyc_timer.sv
module wcyc_timer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(PROG_CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/wcyc_ctrl.sv
module wcyc_ctrl
    import wcyc_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic wprot_n,
    input  logic prot_en,
    input  logic wr_seq_ok,
    input  logic wr_seq_stat,
    output logic busy,
    output logic standby,
    output logic stat_wr_en,
    output logic cyc_start
);
    logic [SYNC_W-1:0] raw_in, syn;
    logic sel_s, wp_s, ok_s, st_s;
    logic blocked, accept, rise_in_sel;
    logic t_last, kind_q;
    wc_state_e state, nxt;

    assign raw_in = {wr_seq_stat, wr_seq_ok, wprot_n, sel_n};

    wcyc_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    assign sel_s = syn[IDX_SEL];
    assign wp_s  = syn[IDX_WP];
    assign ok_s  = syn[IDX_OK];
    assign st_s  = syn[IDX_ST];

    // protection applies only to status writes and only when enabled
    assign blocked     = st_s & prot_en & ~wp_s;
    assign accept      = ok_s & ~blocked;
    assign rise_in_sel = (state == ST_SELECTED) & sel_s;

    wcyc_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(state == ST_LAUNCH), .last(t_last)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_SEL: if (!sel_s) nxt = ST_SELECTED;
            ST_IDLE:     if (!sel_s) nxt = ST_SELECTED;
            ST_SELECTED: if (sel_s)  nxt = accept ? ST_LAUNCH : ST_IDLE;
            ST_LAUNCH:   nxt = ST_PROG;
            ST_PROG:     if (t_last) nxt = sel_s ? ST_IDLE : ST_SELECTED;
            default:     nxt = ST_WAIT_SEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_SEL;
        else        state <= nxt;
    end

    // kind of the launched sequence, frozen for the whole cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     kind_q <= 1'b0;
        else if (rise_in_sel && accept) kind_q <= st_s;
    end

    always_comb begin
        busy       = 1'b0;
        standby    = 1'b0;
        stat_wr_en = 1'b0;
        cyc_start  = 1'b0;
        unique case (state)
            ST_WAIT_SEL: standby = 1'b1;
            ST_IDLE:     standby = 1'b1;
            ST_SELECTED: standby = 1'b0;
            ST_LAUNCH: begin
                busy       = 1'b1;
                cyc_start  = 1'b1;
                stat_wr_en = kind_q;
            end
            ST_PROG:     busy = 1'b1;
            default:     standby = 1'b1;
        endcase
    end
endmodule

// File: rtl/wcyc_ctrl_chk.sv
module wcyc_ctrl_chk #(
    parameter int PROG_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic standby,
    input logic stat_wr_en,
    input logic cyc_start
);
    localparam int RW = $clog2(PROG_CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> busy);

    p_rise_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cyc_start);

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    p_stwr_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |-> cyc_start);

    p_busy_nostby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !standby);

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(PROG_CYCLES)));
endmodule

bind wcyc_ctrl wcyc_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .standby(standby),
    .stat_wr_en(stat_wr_en), .cyc_start(cyc_start)
);

// File: tb/tb_wcyc_ctrl.sv
`timescale 1ns/1ps
module tb_wcyc_ctrl;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, wprot_n = 1'b1, prot_en = 1'b0;
    logic wr_seq_ok = 1'b0, wr_seq_stat = 1'b0;
    logic busy, standby, stat_wr_en, cyc_start;

    int checks = 0, fails = 0;
    int n_start = 0, n_stwr = 0, n_busy = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wcyc_ctrl #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wprot_n(wprot_n),
        .prot_en(prot_en), .wr_seq_ok(wr_seq_ok), .wr_seq_stat(wr_seq_stat),
        .busy(busy), .standby(standby), .stat_wr_en(stat_wr_en), .cyc_start(cyc_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: inputs seen two edges late, rules applied at the edge
    int q_sel[$], q_wp[$], q_ok[$], q_st[$];
    int left = 0;
    bit in_sel = 0, kind = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_sel = '{1, 1}; q_wp = '{1, 1}; q_ok = '{0, 0}; q_st = '{0, 0};
            left = 0; in_sel = 0; kind = 0;
        end else begin
            int s, w, v, k;
            s = q_sel[0]; w = q_wp[0]; v = q_ok[0]; k = q_st[0];
            if (left > 0) begin
                left--;
                if (left == 0) in_sel = (s == 0);
            end else if (in_sel) begin
                if (s == 1) begin
                    if (v == 1 && !(k == 1 && prot_en && w == 0)) begin
                        left = P;
                        kind = k[0];
                    end
                    in_sel = 0;
                end
            end else if (s == 0) begin
                in_sel = 1;
            end
            void'(q_sel.pop_front()); q_sel.push_back(int'(sel_n));
            void'(q_wp.pop_front());  q_wp.push_back(int'(wprot_n));
            void'(q_ok.pop_front());  q_ok.push_back(int'(wr_seq_ok));
            void'(q_st.pop_front());  q_st.push_back(int'(wr_seq_stat));
        end
        #5;
        if (rst_n) begin
            int e_busy, e_start, e_stwr, e_stby;
            e_busy  = (left > 0);
            e_start = (left == P);
            e_stwr  = (left == P) && kind;
            e_stby  = (left == 0) && !in_sel;
            chk(busy == e_busy,        "R4 busy",       busy, e_busy);
            chk(cyc_start == e_start,  "R3 cyc_start",  cyc_start, e_start);
            chk(stat_wr_en == e_stwr,  "R8 stat_wr_en", stat_wr_en, e_stwr);
            chk(standby == e_stby,     "R2 standby",    standby, e_stby);
            n_busy  += busy;
            n_start += cyc_start;
            n_stwr  += stat_wr_en;
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one select frame ending with a rise; returns deltas of counters
    task automatic frame(input bit ok, input bit st, input bit wp, input bit pe,
                         output int d_start, output int d_stwr, output int d_busy);
        int s0, w0, b0;
        s0 = n_start; w0 = n_stwr; b0 = n_busy;
        @(negedge clk);
        prot_en = pe; wprot_n = wp; sel_n = 1'b0;
        wr_seq_ok = ok; wr_seq_stat = st;
        wait_neg(4);
        sel_n = 1'b1;
        wait_neg(4);
        wr_seq_ok = 1'b0; wr_seq_stat = 1'b0;
        wait_neg(P + 6);
        d_start = n_start - s0; d_stwr = n_stwr - w0; d_busy = n_busy - b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ds, dw, db, s0, b0;
        wait_neg(3);
        // R1 reset values
        chk(busy == 0 && cyc_start == 0 && stat_wr_en == 0, "R1 outputs idle", busy, 0);
        chk(standby == 1, "R1 standby", standby, 1);
        rst_n = 1'b1;

        // R10: valid flag before any select-low is ignored
        s0 = n_start;
        @(negedge clk); wr_seq_ok = 1'b1; wr_seq_stat = 1'b1;
        wait_neg(12);
        chk(n_start == s0, "R10 no launch before select", n_start - s0, 0);
        chk(standby == 1, "R10 standby kept", standby, 1);
        wr_seq_ok = 1'b0; wr_seq_stat = 1'b0;

        // R2 standby falls on third edge after sel_n low
        @(negedge clk); sel_n = 1'b0;
        @(posedge clk); #5 chk(standby == 1, "R2 still standby edge1", standby, 1);
        @(posedge clk); #5 chk(standby == 1, "R2 still standby edge2", standby, 1);
        @(posedge clk); #5 chk(standby == 0, "R2 selected edge3", standby, 0);
        // R3 launch latency: rise with valid flag
        @(negedge clk); wr_seq_ok = 1'b1;
        wait_neg(2); sel_n = 1'b1;
        @(posedge clk); #5 chk(cyc_start == 0, "R3 no start edge1", cyc_start, 0);
        @(posedge clk); #5 chk(cyc_start == 0, "R3 no start edge2", cyc_start, 0);
        @(posedge clk); #5 chk(cyc_start == 1, "R3 start edge3", cyc_start, 1);
        @(negedge clk); wr_seq_ok = 1'b0;
        wait_neg(P + 4);

        // R11 plain write while protected
        frame(1, 0, 0, 1, ds, dw, db);
        chk(ds == 1, "R11 plain write launches", ds, 1);
        chk(dw == 0, "R11 no status strobe", dw, 0);
        chk(db == P, "R4 busy length", db, P);

        // R7 blocked status write
        frame(1, 1, 0, 1, ds, dw, db);
        chk(ds == 0, "R7 blocked start", ds, 0);
        chk(db == 0, "R7 blocked busy", db, 0);
        chk(dw == 0, "R7 blocked strobe", dw, 0);

        // R8 protect disabled, pin low
        frame(1, 1, 0, 0, ds, dw, db);
        chk(ds == 1 && dw == 1, "R8 status write with prot_en=0", dw, 1);

        // R12 rise without valid sequence
        frame(0, 0, 1, 0, ds, dw, db);
        chk(ds == 0, "R12 no launch", ds, 0);
        chk(standby == 1, "R12 back to standby", standby, 1);

        // R9 and R5: launch, then wp drops and select toggles during busy
        s0 = n_start; b0 = n_busy;
        @(negedge clk); prot_en = 1'b1; wprot_n = 1'b1; sel_n = 1'b0;
        wr_seq_ok = 1'b1; wr_seq_stat = 1'b1;
        wait_neg(4); sel_n = 1'b1;
        wait_neg(4); wprot_n = 1'b0;          // busy already high
        sel_n = 1'b0; wait_neg(1); sel_n = 1'b1; wait_neg(1);
        sel_n = 1'b0;                           // stays low past the end
        wr_seq_ok = 1'b0; wr_seq_stat = 1'b0;
        wait_neg(P + 4);
        chk(n_start - s0 == 1, "R5 single launch", n_start - s0, 1);
        chk(n_busy - b0 == P, "R9 busy length unchanged", n_busy - b0, P);
        // R6 select low at end: no standby until select rises
        chk(standby == 0, "R6 no standby while selected", standby, 0);
        sel_n = 1'b1; wait_neg(4);
        chk(standby == 1, "R6 standby after deselect", standby, 1);
        wprot_n = 1'b1;
        wait_neg(4);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule